// File: doc/BRIEF.md
# Cross Trigger Routing Matrix

This block is a debug cross-trigger router. Eight trigger input lines are folded onto four shared event channels. The four channels then fan back out onto eight trigger output lines. Every input owns a 4-bit channel mask that says which channels it raises. Every output owns a 4-bit channel mask that says which channels may fire it. Any input can therefore reach any output through one or more channels. Debug logic elsewhere on the chip uses this to stop, start or mark several cores from a single event.

Trigger inputs are asynchronous. They pass through a two-flop synchroniser, and the synchronised levels feed both the routing and a read-only level register. Software programs the masks over a plain 32-bit register bus with address, write enable, write data and combinational read data. Each output is registered. It follows its enabled channels with a latency of one clock.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset every input mask and every output mask reads 0, the status register reads 0 and every trigger output is low.
- R2: The input mask for input i (i = 0..7) is at offset 0x020 + 4*i. A write stores bits 3:0, where bit c selects channel c. A read returns those 4 bits with bits 31:4 as zero.
- R3: The output mask for output j (j = 0..7) is at offset 0x0A0 + 4*j. A write stores bits 3:0, where bit c selects channel c. A read returns those 4 bits with bits 31:4 as zero.
- R4: The status register at offset 0x130 returns the synchronised input levels in bits 7:0, with bit i for input i, and zero in bits 31:8. A change on an input becomes visible there after two rising clock edges.
- R5: Channel c is active while at least one synchronised input i has bit c of its input mask set. Output j is driven high when at least one channel selected by its output mask is active.
- R6: An output goes high on the clock edge after its channel becomes active, which is three edges after the input changes. It stays high as long as that channel stays active and falls with the same latency.
- R7: An input whose mask is 0 raises no channel, and an output whose mask is 0 never fires.
- R8: A read from any other offset returns 0, including unaligned offsets. A write to the status register or to any unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigIn | input | 8 | Asynchronous trigger input levels |
| trigOut | output | 8 | Registered trigger outputs |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The hardest case to reach is an output whose level depends on several inputs arriving through different, overlapping channels. In that case a fault in one OR term is masked by another input that is also active. To reach it, the bench loads three mask configurations computed arithmetically. One is sparse and one-hot, one is dense and overlapping, and one is mostly zero. Under each configuration it sweeps all 256 input patterns, holds each pattern until the pipeline has settled, and compares every output with the value predicted from the masks. A separate single-edge probe pins down the exact cycle in which the status register and the output change.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;
  localparam int NUM_IN  = 8;
  localparam int NUM_OUT = 8;
  localparam int NUM_CH  = 4;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int IDX_W   = $clog2((NUM_IN > NUM_OUT) ? NUM_IN : NUM_OUT);

  localparam logic [ADDR_W-1:0] IN_BASE   = 12'h020;
  localparam logic [ADDR_W-1:0] OUT_BASE  = 12'h0A0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h130;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_INMASK,
    RD_OUTMASK,
    RD_STATUS
  } rdSrc_t;

  typedef struct packed {
    logic [NUM_IN-1:0]  inWr;
    logic [NUM_OUT-1:0] outWr;
    rdSrc_t             rdSrc;
    logic [IDX_W-1:0]   rdIdx;
  } regStb_t;
endpackage

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
  import xtrig_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStb_t           stb
);
  localparam logic [ADDR_W-1:0] IN_END  = IN_BASE + ADDR_W'(4 * NUM_IN);
  localparam logic [ADDR_W-1:0] OUT_END = OUT_BASE + ADDR_W'(4 * NUM_OUT);

  logic [ADDR_W-1:0] inOff;
  logic [ADDR_W-1:0] outOff;
  logic              aligned;
  logic              inHit;
  logic              outHit;
  logic              statHit;
  logic [IDX_W-1:0]  inIdx;
  logic [IDX_W-1:0]  outIdx;

  always_comb begin
    inOff   = busAddr - IN_BASE;
    outOff  = busAddr - OUT_BASE;
    inIdx   = inOff[2 +: IDX_W];
    outIdx  = outOff[2 +: IDX_W];
    aligned = (busAddr[1:0] == 2'b00);
    inHit   = aligned && (busAddr >= IN_BASE) && (busAddr < IN_END);
    outHit  = aligned && (busAddr >= OUT_BASE) && (busAddr < OUT_END);
    statHit = (busAddr == STAT_ADDR);

    stb       = '0;
    stb.rdSrc = RD_NONE;
    if (inHit) begin
      stb.rdSrc = RD_INMASK;
      stb.rdIdx = inIdx;
      if (busWrEn) stb.inWr[inIdx] = 1'b1;
    end else if (outHit) begin
      stb.rdSrc = RD_OUTMASK;
      stb.rdIdx = outIdx;
      if (busWrEn) stb.outWr[outIdx] = 1'b1;
    end else if (statHit) begin
      stb.rdSrc = RD_STATUS;
    end
  end
endmodule

// File: rtl/xtrig_datapath.sv
module xtrig_datapath
  import xtrig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] trigIn,
  input  regStb_t           stb,
  input  logic [NUM_CH-1:0] wrMask,
  output logic [NUM_OUT-1:0] trigOut,
  output logic [DATA_W-1:0] rdData
);
  logic [NUM_IN-1:0] syncQ [SYNC_STAGES];
  logic [NUM_IN-1:0] trigLvl;
  logic [NUM_CH-1:0] inMask  [NUM_IN];
  logic [NUM_CH-1:0] outMask [NUM_OUT];
  logic [NUM_CH-1:0] chanAct;

  // input synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= trigIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign trigLvl = syncQ[SYNC_STAGES-1];

  // per-input channel masks
  for (genvar i = 0; i < NUM_IN; i++) begin : g_inMask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             inMask[i] <= '0;
      else if (stb.inWr[i])  inMask[i] <= wrMask;
    end
  end

  // per-output channel masks
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_outMask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             outMask[j] <= '0;
      else if (stb.outWr[j]) outMask[j] <= wrMask;
    end
  end

  // first stage: inputs onto channels
  always_comb begin
    chanAct = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (trigLvl[i]) chanAct = chanAct | inMask[i];
    end
  end

  // second stage: channels onto registered outputs
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) trigOut[j] <= 1'b0;
      else       trigOut[j] <= |(outMask[j] & chanAct);
    end
  end

  // read mux
  always_comb begin
    unique case (stb.rdSrc)
      RD_INMASK:  rdData = DATA_W'(inMask[stb.rdIdx]);
      RD_OUTMASK: rdData = DATA_W'(outMask[stb.rdIdx]);
      RD_STATUS:  rdData = DATA_W'(trigLvl);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix
  import xtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  trigIn,
  output logic [7:0]  trigOut,
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData
);
  regStb_t stb;

  xtrig_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  xtrig_datapath #(.SYNC_STAGES(2)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .trigIn  (trigIn),
    .stb     (stb),
    .wrMask  (busWrData[NUM_CH-1:0]),
    .trigOut (trigOut),
    .rdData  (busRdData)
  );
endmodule

// File: rtl/xtrig_matrix_chk.sv
module xtrig_matrix_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  trigIn,
  input logic [7:0]  trigOut,
  input logic [11:0] busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData
);
  logic [7:0] lvl1, lvl2;
  logic [3:0] shIn  [8];
  logic [3:0] shOut [8];
  logic [3:0] shChan;
  logic [7:0] shNext;
  logic [7:0] expOut;
  logic       inZero;
  logic       writable;

  always_comb begin
    shChan = '0;
    for (int i = 0; i < 8; i++) if (lvl2[i]) shChan = shChan | shIn[i];
    for (int j = 0; j < 8; j++) shNext[j] = |(shOut[j] & shChan);
    inZero = 1'b1;
    for (int i = 0; i < 8; i++) if (shIn[i] != 4'd0) inZero = 1'b0;
    writable = (busAddr[1:0] == 2'b00) &&
               (((busAddr >= 12'h020) && (busAddr < 12'h040)) ||
                ((busAddr >= 12'h0A0) && (busAddr < 12'h0C0)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl1   <= '0;
      lvl2   <= '0;
      expOut <= '0;
      for (int k = 0; k < 8; k++) begin
        shIn[k]  <= '0;
        shOut[k] <= '0;
      end
    end else begin
      lvl1   <= trigIn;
      lvl2   <= lvl1;
      expOut <= shNext;
      if (busWrEn && writable) begin
        if (busAddr < 12'h040) shIn[busAddr[4:2]]  <= busWrData[3:0];
        else                   shOut[busAddr[4:2]] <= busWrData[3:0];
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> trigOut == 8'h00);

  // R4
  status_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 12'h130) |-> (busRdData == {24'h0, lvl2}));

  // R2
  mask_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && writable) ##1 (busAddr == $past(busAddr)) |->
      (busRdData == {28'h0, $past(busWrData[3:0])}));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != 12'h130) |-> (busRdData[31:4] == 28'h0));

  // R5
  routing_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut == expOut);

  // R7
  silent_masks_chk: assert property (@(posedge clk) disable iff (!rstN)
    inZero && $past(inZero) |=> trigOut == 8'h00);
endmodule

bind xtrig_matrix xtrig_matrix_chk u_chk (.*);

// File: tb/tb_xtrig_matrix.sv
module tb_xtrig_matrix;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  trigIn = '0;
  logic [7:0]  trigOut;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] mIn  [8];
  logic [3:0] mOut [8];

  always #4 clk = ~clk;

  xtrig_matrix dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(req, busRdData, exp);
  endtask

  function automatic logic [7:0] predict(input logic [7:0] p);
    logic [3:0] ch = '0;
    logic [7:0] o;
    for (int i = 0; i < 8; i++) if (p[i]) ch = ch | mIn[i];
    for (int j = 0; j < 8; j++) o[j] = |(mOut[j] & ch);
    return o;
  endfunction

  task automatic loadCfg(input int kind);
    for (int i = 0; i < 8; i++) begin
      case (kind)
        0: begin mIn[i] = 4'(1 << (i % 4)); mOut[i] = 4'(1 << ((i + 1) % 4)); end
        1: begin mIn[i] = 4'((i * 7 + 3) % 16); mOut[i] = 4'((i * 5 + 9) % 16); end
        default: begin mIn[i] = (i == 2) ? 4'b1000 : 4'b0000; mOut[i] = (i % 2 == 0) ? 4'hF : 4'h0; end
      endcase
      wrReg(12'h020 + 12'(4 * i), {28'hFFFFFFF, mIn[i]});
      wrReg(12'h0A0 + 12'(4 * i), {28'hABCDEF0, mOut[i]});
    end
  endtask

  task automatic sweep(input string req);
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      trigIn = 8'(p);
      repeat (3) @(posedge clk);
      #1;
      chk(req, {24'h0, trigOut}, {24'h0, predict(8'(p))});
    end
  endtask

  initial begin
    #2_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    chk("R1 trigOut", {24'h0, trigOut}, 32'h0);
    for (int k = 0; k < 8; k++) begin
      rdChk("R1 in mask", 12'h020 + 12'(4 * k), 32'h0);
      rdChk("R1 out mask", 12'h0A0 + 12'(4 * k), 32'h0);
    end
    rdChk("R1 status", 12'h130, 32'h0);

    // R2 / R3 register map with reserved bits
    for (int k = 0; k < 8; k++) begin
      wrReg(12'h020 + 12'(4 * k), 32'hFFFF_FFF0 | 32'((k * 5 + 3) % 16));
      wrReg(12'h0A0 + 12'(4 * k), 32'h5A5A_5A50 | 32'((k * 3 + 1) % 16));
    end
    for (int k = 0; k < 8; k++) begin
      rdChk("R2 in mask", 12'h020 + 12'(4 * k), 32'((k * 5 + 3) % 16));
      rdChk("R3 out mask", 12'h0A0 + 12'(4 * k), 32'((k * 3 + 1) % 16));
    end

    // R8 unmapped and read-only writes
    wrReg(12'h130, 32'hFFFF_FFFF);
    wrReg(12'h040, 32'hFFFF_FFFF);
    wrReg(12'h021, 32'hFFFF_FFFF);
    wrReg(12'h0C0, 32'hFFFF_FFFF);
    rdChk("R8 status after write", 12'h130, 32'h0);
    rdChk("R8 unmapped 0x000", 12'h000, 32'h0);
    rdChk("R8 unmapped 0x01C", 12'h01C, 32'h0);
    rdChk("R8 unmapped 0x040", 12'h040, 32'h0);
    rdChk("R8 unaligned 0x021", 12'h021, 32'h0);
    rdChk("R8 unmapped 0x0C0", 12'h0C0, 32'h0);
    rdChk("R8 unmapped 0x134", 12'h134, 32'h0);
    rdChk("R8 in0 kept", 12'h020, 32'd3);
    rdChk("R8 out7 kept", 12'h0BC, 32'((7 * 3 + 1) % 16));

    // R7 masks all zero: no output fires
    for (int k = 0; k < 8; k++) wrReg(12'h020 + 12'(4 * k), 32'h0);
    @(negedge clk) trigIn = 8'hFF;
    repeat (4) @(posedge clk);
    #1 chk("R7 zero input masks", {24'h0, trigOut}, 32'h0);
    @(negedge clk) trigIn = 8'h00;

    // R4 / R6 exact latency probe
    for (int k = 0; k < 8; k++) begin
      wrReg(12'h020 + 12'(4 * k), (k == 0) ? 32'h1 : 32'h0);
      wrReg(12'h0A0 + 12'(4 * k), (k == 0) ? 32'h1 : 32'h0);
    end
    busAddr = 12'h130;
    repeat (4) @(posedge clk);
    @(negedge clk) trigIn = 8'h01;
    @(posedge clk); #1;
    chk("R4 status after one edge", busRdData, 32'h0);
    @(posedge clk); #1;
    chk("R4 status after two edges", busRdData, 32'h1);
    chk("R6 output before its edge", {24'h0, trigOut}, 32'h0);
    @(posedge clk); #1;
    chk("R6 output after three edges", {24'h0, trigOut}, 32'h1);
    @(negedge clk) trigIn = 8'h00;
    repeat (2) @(posedge clk); #1;
    chk("R6 output held while channel active", {24'h0, trigOut}, 32'h1);
    @(posedge clk); #1;
    chk("R6 output falls", {24'h0, trigOut}, 32'h0);

    // R5 exhaustive sweeps over three configurations
    loadCfg(0); sweep("R5 one-hot masks");
    loadCfg(1); sweep("R5 overlapping masks");
    loadCfg(2); sweep("R7 mostly zero masks");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule